// File: doc/BRIEF.md
# Registered Multiply-Accumulate Unit

This block is a 16 x 16 multiplier with a 35-bit accumulating result register, meant for filter and correlation loops in signal processing. Each operand has its own input register and its own clock. The X register also samples the operation controls: signed or unsigned operands, accumulate, subtract and rounding. On the next edge of the result clock, the captured product is either loaded into the result register, added to it or subtracted from it. When rounding is requested, a half-LSB of the most significant field is added as well.

The result register is split into three fields. The extended field is bits 34:32, the most significant field is bits 31:16 and the least significant field is bits 15:0. Each field has its own output-enable flag, which stands in for a three-state driver.

The least significant field shares its bus with the Y operand input. A preload control writes external data straight into the fields whose enables are inactive, and it bypasses the arithmetic on that edge.

Top module: `mac16_unit`

## Requirements
- R1: An active-low asynchronous reset clears the three result fields, both operand registers and the control register. The first result-clock edge after reset therefore loads zero.
- R2: With tc=0, acc_en=0, sub_en=0 and rnd_en=0, the result register is loaded with the unsigned product, zero-extended to 35 bits.
  - The fields are laid out as ext_q = bits 34:32, msp_q = bits 31:16 and lsp_q = bits 15:0.
  - The result changes on the clk_p edge that follows the edge capturing the operands.
- R3: With tc=1, both operands are read as two's-complement values, and the product is sign-extended to 35 bits.
- R4: With acc_en=1 and sub_en=0, the new result is the current result plus the product.
- R5: With sub_en=1, the new result is the current result minus the product, whatever the value of acc_en.
- R6: With rnd_en=1, the value 0x8000 (a one at bit 15) is added after the load, add or subtract step.
- R7: All arithmetic wraps modulo 2^35 with no overflow indication.
- R8: On a clk_p edge with preload=1, each field whose enable is 0 takes its bus value. The buses are ext_pl for the extended field, msp_pl for the most significant field and ybus_in for the least significant field.
- R9: On a clk_p edge with preload=1, a field whose enable is 1 holds its value, and the product is not applied to any field on that edge.
- R10: The Y operand is captured from the shared bus ybus_in on clk_y, and the X operand from x_in on clk_x.
- R11: The operation controls are captured on the same clk_x edge as X. A change to them after that edge does not alter the pending operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x | input | 1 | Clock for the X operand and control registers |
| clk_y | input | 1 | Clock for the Y operand register |
| clk_p | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | 16 | X operand |
| ybus_in | input | 16 | Shared bus: Y operand and least-significant preload data |
| tc | input | 1 | 1 = signed operands, 0 = unsigned |
| acc_en | input | 1 | Accumulate the product into the result |
| sub_en | input | 1 | Subtract the product from the result |
| rnd_en | input | 1 | Add 0x8000 to the result |
| preload | input | 1 | Load disabled fields from their buses |
| oe_ext | input | 1 | Extended field drives its bus |
| oe_msp | input | 1 | Most significant field drives its bus |
| oe_lsp | input | 1 | Least significant field drives the shared bus |
| ext_pl | input | 3 | Preload data for the extended field |
| msp_pl | input | 16 | Preload data for the most significant field |
| ext_q | output | 3 | Extended result field |
| msp_q | output | 16 | Most significant result field |
| lsp_q | output | 16 | Least significant result field |

## Verification
A vector sequence is streamed through the pipeline, with each result checked one cycle after its operands. The sequence uses the extreme operands (all ones, the most negative value and the largest positive value) in both unsigned and signed mode. This separates zero-extension from sign-extension, and it exposes a missing correction term in the product. Some vectors chain accumulate, subtract, both together, and rounding on top of a known prior result, so that operation priority and the place where the rounding constant is added can be told apart. One sum crosses 2^35 to show the wrap. Directed sequences cover:
- mixed enables during preload;
- a preload that must discard a pending product;
- a change of controls just after capture;
- a reset in the middle of a run.

// File: rtl/mac16_pkg.sv
`timescale 1ns/1ps
package mac16_pkg;

   // Operation controls captured together with the X operand
   typedef struct packed {
      logic tc;
      logic acc;
      logic sub;
      logic rnd;
   } mac_ctl_t;

   localparam int unsigned CTL_W = $bits(mac_ctl_t);

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_ADD  = 2'd1,
      OP_SUB  = 2'd2
   } mac_op_e;

   // Subtract takes priority over accumulate
   function automatic mac_op_e decode_op(input mac_ctl_t c);
      if (c.sub)      return OP_SUB;
      else if (c.acc) return OP_ADD;
      else            return OP_LOAD;
   endfunction

endpackage

// File: rtl/mac16_capture.sv
`timescale 1ns/1ps
module mac16_capture #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("mac16_capture: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/mac16_mult.sv
`timescale 1ns/1ps
module mac16_mult #(
   parameter int unsigned XW          = 16,
   parameter int unsigned YW          = 16,
   parameter int unsigned PW          = 35,
   parameter bit          SIGNED_CORE = 1'b1
) (
   input  logic [XW-1:0] x,
   input  logic [YW-1:0] y,
   input  logic          tc,
   output logic [PW-1:0] prod
);

   localparam int unsigned RAW_W = XW + YW;

   generate
      if (PW < RAW_W + 1) begin : g_bad_pw
         $error("mac16_mult: PW must exceed XW+YW");
      end

      if (SIGNED_CORE) begin : g_signed
         // One (XW+1) x (YW+1) signed multiply on operands extended by one bit
         logic signed [XW:0]      xa;
         logic signed [YW:0]      ya;
         logic signed [RAW_W+1:0] pm;
         assign xa = {tc & x[XW-1], x};
         assign ya = {tc & y[YW-1], y};
         assign pm = xa * ya;
         if (PW > RAW_W + 2) begin : g_ext
            assign prod = {{(PW-RAW_W-2){pm[RAW_W+1]}}, pm};
         end else begin : g_trunc
            assign prod = pm[PW-1:0];
         end
      end else begin : g_unsigned
         // Unsigned array product, then correction terms for the sign weights
         logic [RAW_W-1:0] uxy;
         logic [PW-1:0]    ufull, cor_x, cor_y, cor_xy;
         logic             xs, ys;
         assign xs     = tc & x[XW-1];
         assign ys     = tc & y[YW-1];
         assign uxy    = {{YW{1'b0}}, x} * {{XW{1'b0}}, y};
         assign ufull  = {{(PW-RAW_W){1'b0}}, uxy};
         assign cor_x  = xs ? ({{(PW-YW){1'b0}}, y} << XW) : '0;
         assign cor_y  = ys ? ({{(PW-XW){1'b0}}, x} << YW) : '0;
         assign cor_xy = (xs & ys) ? ({{(PW-1){1'b0}}, 1'b1} << RAW_W) : '0;
         assign prod   = ufull - cor_x - cor_y + cor_xy;
      end
   endgenerate

endmodule

// File: rtl/mac16_accum.sv
`timescale 1ns/1ps
module mac16_accum
   import mac16_pkg::*;
#(
   parameter int unsigned PW      = 35,
   parameter int unsigned RND_BIT = 15
) (
   input  logic [PW-1:0] cur,
   input  logic [PW-1:0] prod,
   input  mac_ctl_t      ctl,
   output logic [PW-1:0] nxt
);

   localparam logic [PW-1:0] RND_ONE = {{(PW-1){1'b0}}, 1'b1} << RND_BIT;

   generate
      if (RND_BIT >= PW) begin : g_bad_rnd
         $error("mac16_accum: RND_BIT out of range");
      end
   endgenerate

   logic [PW-1:0] base;

   always_comb begin
      unique case (decode_op(ctl))
         OP_ADD:  base = cur + prod;
         OP_SUB:  base = cur - prod;
         default: base = prod;
      endcase
      nxt = base + (ctl.rnd ? RND_ONE : '0);
   end

endmodule

// File: rtl/mac16_field.sv
`timescale 1ns/1ps
module mac16_field #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pl_en,
   input  logic         oe,
   input  logic [W-1:0] pl_d,
   input  logic [W-1:0] calc_d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (pl_en) begin
         // Field takes bus data only while it is not driving the bus
         if (!oe) q <= pl_d;
      end else begin
         q <= calc_d;
      end
   end

endmodule

// File: rtl/mac16_unit.sv
`timescale 1ns/1ps
module mac16_unit
   import mac16_pkg::*;
#(
   parameter int unsigned XW          = 16,
   parameter int unsigned YW          = 16,
   parameter int unsigned EXTW        = 3,
   parameter bit          SIGNED_CORE = 1'b1
) (
   input  logic            clk_x,
   input  logic            clk_y,
   input  logic            clk_p,
   input  logic            rst_n,
   input  logic [XW-1:0]   x_in,
   input  logic [YW-1:0]   ybus_in,
   input  logic            tc,
   input  logic            acc_en,
   input  logic            sub_en,
   input  logic            rnd_en,
   input  logic            preload,
   input  logic            oe_ext,
   input  logic            oe_msp,
   input  logic            oe_lsp,
   input  logic [EXTW-1:0] ext_pl,
   input  logic [XW-1:0]   msp_pl,
   output logic [EXTW-1:0] ext_q,
   output logic [XW-1:0]   msp_q,
   output logic [YW-1:0]   lsp_q
);

   localparam int unsigned LSW     = YW;
   localparam int unsigned MSW     = XW;
   localparam int unsigned ACCW    = EXTW + MSW + LSW;
   localparam int unsigned RND_BIT = LSW - 1;
   localparam int unsigned NFLD    = 3;

   generate
      if (XW < 2 || YW < 2) begin : g_bad_ops
         $error("mac16_unit: operands need at least 2 bits");
      end
      if (EXTW < 3) begin : g_bad_ext
         $error("mac16_unit: EXTW must be at least 3");
      end
   endgenerate

   // Operand and control capture
   logic [XW-1:0]    x_q;
   logic [YW-1:0]    y_q;
   logic [CTL_W-1:0] ctl_bits;
   mac_ctl_t         ctl_d, ctl_q;

   assign ctl_d = '{tc: tc, acc: acc_en, sub: sub_en, rnd: rnd_en};
   assign ctl_q = mac_ctl_t'(ctl_bits);

   mac16_capture #(.W(XW)) u_xreg (
      .clk(clk_x), .rst_n(rst_n), .d(x_in), .q(x_q)
   );

   mac16_capture #(.W(YW)) u_yreg (
      .clk(clk_y), .rst_n(rst_n), .d(ybus_in), .q(y_q)
   );

   mac16_capture #(.W(CTL_W)) u_ctlreg (
      .clk(clk_x), .rst_n(rst_n), .d(ctl_d), .q(ctl_bits)
   );

   // Arithmetic
   logic [ACCW-1:0] prod_w, nxt_w, res_q;

   mac16_mult #(
      .XW(XW), .YW(YW), .PW(ACCW), .SIGNED_CORE(SIGNED_CORE)
   ) u_mult (
      .x(x_q), .y(y_q), .tc(ctl_q.tc), .prod(prod_w)
   );

   mac16_accum #(.PW(ACCW), .RND_BIT(RND_BIT)) u_accum (
      .cur(res_q), .prod(prod_w), .ctl(ctl_q), .nxt(nxt_w)
   );

   // Result fields: index 0 = low, 1 = middle, 2 = extended
   logic [ACCW-1:0] pl_bus;
   logic [NFLD-1:0] oe_vec;

   assign pl_bus = {ext_pl, msp_pl, ybus_in};
   assign oe_vec = {oe_ext, oe_msp, oe_lsp};

   for (genvar g = 0; g < NFLD; g++) begin : g_fld
      localparam int unsigned LO = (g == 0) ? 0   : (g == 1) ? LSW : LSW + MSW;
      localparam int unsigned FW = (g == 0) ? LSW : (g == 1) ? MSW : EXTW;
      mac16_field #(.W(FW)) u_fld (
         .clk   (clk_p),
         .rst_n (rst_n),
         .pl_en (preload),
         .oe    (oe_vec[g]),
         .pl_d  (pl_bus[LO +: FW]),
         .calc_d(nxt_w[LO +: FW]),
         .q     (res_q[LO +: FW])
      );
   end

   assign lsp_q = res_q[LSW-1:0];
   assign msp_q = res_q[LSW +: MSW];
   assign ext_q = res_q[ACCW-1 -: EXTW];

endmodule

// File: rtl/mac16_unit_chk.sv
`timescale 1ns/1ps
module mac16_unit_chk #(
   parameter int unsigned ACCW = 35,
   parameter int unsigned EXTW = 3,
   parameter int unsigned MSW  = 16,
   parameter int unsigned LSW  = 16
) (
   input logic            clk_p,
   input logic            rst_n,
   input logic            preload,
   input logic            oe_ext,
   input logic            oe_msp,
   input logic            oe_lsp,
   input logic [EXTW-1:0] ext_pl,
   input logic [MSW-1:0]  msp_pl,
   input logic [LSW-1:0]  ybus_in,
   input logic [ACCW-1:0] res,
   input logic [ACCW-1:0] prod,
   input logic            acc_q,
   input logic            sub_q,
   input logic            rnd_q
);

   localparam logic [ACCW-1:0] HALF = {{(ACCW-1){1'b0}}, 1'b1} << (LSW - 1);

   // R2: plain load takes the product
   p_plain_load_r2: assert property (@(posedge clk_p) disable iff (!rst_n)
      (!preload && !acc_q && !sub_q && !rnd_q) |=> (res == $past(prod)));

   // R4: accumulate adds the product (R7: modulo width)
   p_accum_r4: assert property (@(posedge clk_p) disable iff (!rst_n)
      (!preload && acc_q && !sub_q && !rnd_q) |=> (res == $past(res) + $past(prod)));

   // R5: subtract wins over accumulate
   p_sub_r5: assert property (@(posedge clk_p) disable iff (!rst_n)
      (!preload && sub_q && !rnd_q) |=> (res == $past(res) - $past(prod)));

   // R6: rounding adds the half constant
   p_round_r6: assert property (@(posedge clk_p) disable iff (!rst_n)
      (!preload && !acc_q && !sub_q && rnd_q) |=> (res == $past(prod) + HALF));

   // R8: disabled fields take bus data on preload
   p_pl_ext_r8: assert property (@(posedge clk_p) disable iff (!rst_n)
      (preload && !oe_ext) |=> (res[ACCW-1 -: EXTW] == $past(ext_pl)));
   p_pl_msp_r8: assert property (@(posedge clk_p) disable iff (!rst_n)
      (preload && !oe_msp) |=> (res[LSW +: MSW] == $past(msp_pl)));
   p_pl_lsp_r8: assert property (@(posedge clk_p) disable iff (!rst_n)
      (preload && !oe_lsp) |=> (res[LSW-1:0] == $past(ybus_in)));

   // R9: enabled fields hold during preload
   p_hold_ext_r9: assert property (@(posedge clk_p) disable iff (!rst_n)
      (preload && oe_ext) |=> $stable(res[ACCW-1 -: EXTW]));
   p_hold_msp_r9: assert property (@(posedge clk_p) disable iff (!rst_n)
      (preload && oe_msp) |=> $stable(res[LSW +: MSW]));
   p_hold_lsp_r9: assert property (@(posedge clk_p) disable iff (!rst_n)
      (preload && oe_lsp) |=> $stable(res[LSW-1:0]));

endmodule

bind mac16_unit mac16_unit_chk #(
   .ACCW(ACCW), .EXTW(EXTW), .MSW(MSW), .LSW(LSW)
) u_chk (
   .clk_p  (clk_p),
   .rst_n  (rst_n),
   .preload(preload),
   .oe_ext (oe_ext),
   .oe_msp (oe_msp),
   .oe_lsp (oe_lsp),
   .ext_pl (ext_pl),
   .msp_pl (msp_pl),
   .ybus_in(ybus_in),
   .res    (res_q),
   .prod   (prod_w),
   .acc_q  (ctl_q.acc),
   .sub_q  (ctl_q.sub),
   .rnd_q  (ctl_q.rnd)
);

// File: tb/mac16_unit_test.sv
`timescale 1ns/1ps
module mac16_unit_test;

   typedef struct packed {
      logic        tc;
      logic        acc;
      logic        sub;
      logic        rnd;
      logic [15:0] x;
      logic [15:0] y;
      logic [34:0] exp;
   } vec_t;

   localparam int NV = 14;

   // Each result appears one cycle after its operands are captured
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0003, 16'h0005, 35'h0_0000_000F},
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 35'h0_FFFE_0001},
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 35'h7_FFFF_FFFF},
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h8000, 35'h0_4000_0000},
      '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0002, 16'h0003, 35'h0_4000_0006},
      '{1'b1, 1'b0, 1'b1, 1'b0, 16'h0001, 16'h0004, 35'h0_4000_0002},
      '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0001, 16'h0001, 35'h0_0000_8001},
      '{1'b1, 1'b1, 1'b1, 1'b0, 16'h0003, 16'h0002, 35'h0_0000_7FFB},
      '{1'b1, 1'b0, 1'b1, 1'b1, 16'h0010, 16'h0100, 35'h0_0000_EFFB},
      '{1'b1, 1'b0, 1'b0, 1'b0, 16'h7FFF, 16'h8000, 35'h7_C000_8000},
      '{1'b1, 1'b1, 1'b0, 1'b0, 16'h8000, 16'h7FFF, 35'h7_8001_0000},
      '{1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 35'h0_7FFF_0001},
      '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0000, 35'h0_7FFF_8001},
      '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 35'h0_0000_0000}
   };

   localparam string TAGS [NV] = '{
      "R2 R10", "R2", "R3", "R3", "R4", "R5", "R6",
      "R5", "R6", "R3", "R4", "R7", "R6", "R11"
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] x_in, ybus_in, msp_pl;
   logic [2:0]  ext_pl, ext_q;
   logic        tc, acc_en, sub_en, rnd_en, preload, oe_ext, oe_msp, oe_lsp;
   logic [15:0] msp_q, lsp_q;
   logic [34:0] res_obs;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   assign res_obs = {ext_q, msp_q, lsp_q};

   mac16_unit uut (
      .clk_x(clk), .clk_y(clk), .clk_p(clk), .rst_n(rst_n),
      .x_in(x_in), .ybus_in(ybus_in),
      .tc(tc), .acc_en(acc_en), .sub_en(sub_en), .rnd_en(rnd_en),
      .preload(preload), .oe_ext(oe_ext), .oe_msp(oe_msp), .oe_lsp(oe_lsp),
      .ext_pl(ext_pl), .msp_pl(msp_pl),
      .ext_q(ext_q), .msp_q(msp_q), .lsp_q(lsp_q)
   );

   task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive_op(input logic t, input logic a, input logic s, input logic r,
                           input logic [15:0] x, input logic [15:0] y);
      tc = t; acc_en = a; sub_en = s; rnd_en = r; x_in = x; ybus_in = y;
   endtask

   task automatic drive_pl(input logic pl, input logic oex, input logic oem, input logic oel,
                           input logic [2:0] e, input logic [15:0] m);
      preload = pl; oe_ext = oex; oe_msp = oem; oe_lsp = oel; ext_pl = e; msp_pl = m;
   endtask

   initial begin
      rst_n = 1'b0;
      drive_op(0, 0, 0, 0, 16'h0, 16'h0);
      drive_pl(0, 0, 0, 0, 3'h0, 16'h0);
      repeat (3) @(negedge clk);
      check("R1 reset state", res_obs, 35'h0);
      rst_n = 1'b1;

      // Vector table streamed through the pipeline
      for (int k = 0; k < NV; k++) begin
         drive_op(VECS[k].tc, VECS[k].acc, VECS[k].sub, VECS[k].rnd, VECS[k].x, VECS[k].y);
         @(negedge clk);
         if (k > 0) check(TAGS[k-1], res_obs, VECS[k-1].exp);
      end
      drive_op(0, 0, 0, 0, 16'h0, 16'h0);
      @(negedge clk);
      check(TAGS[NV-1], res_obs, VECS[NV-1].exp);

      // R8: preload every field (acc with x=0 keeps the pending op neutral)
      drive_pl(1, 0, 0, 0, 3'h5, 16'h1234);
      drive_op(0, 1, 0, 0, 16'h0, 16'hABCD);
      @(negedge clk);
      check("R8 full preload, lsp from shared bus", res_obs, {3'h5, 16'h1234, 16'hABCD});

      // R8 and R9: only the middle field is disabled
      drive_pl(1, 1, 0, 1, 3'h2, 16'hBEEF);
      drive_op(0, 1, 0, 0, 16'h0, 16'h1111);
      @(negedge clk);
      check("R9 mixed enables during preload", res_obs, {3'h5, 16'hBEEF, 16'hABCD});

      // R9: a pending product is discarded by preload with all fields enabled
      drive_pl(0, 1, 1, 1, 3'h0, 16'h0);
      drive_op(0, 0, 0, 0, 16'h3, 16'h5);
      @(negedge clk);
      check("R9 acc of zero", res_obs, {3'h5, 16'hBEEF, 16'hABCD});
      drive_pl(1, 1, 1, 1, 3'h0, 16'h0);
      drive_op(0, 1, 0, 0, 16'h0, 16'h0);
      @(negedge clk);
      check("R9 preload bypasses pending product", res_obs, {3'h5, 16'hBEEF, 16'hABCD});

      // R11: controls follow the operands they were captured with
      drive_pl(1, 0, 0, 0, 3'h7, 16'hFFFF);
      drive_op(0, 1, 0, 0, 16'h0, 16'hFFFF);
      @(negedge clk);
      check("R8 preload all ones", res_obs, 35'h7_FFFF_FFFF);
      drive_pl(0, 0, 0, 0, 3'h0, 16'h0);
      drive_op(0, 0, 0, 0, 16'h2, 16'h2);
      @(negedge clk);
      check("R4 acc of zero keeps value", res_obs, 35'h7_FFFF_FFFF);
      drive_op(0, 1, 0, 0, 16'h1, 16'h1);
      @(negedge clk);
      check("R11 late control change ignored", res_obs, 35'h0_0000_0004);
      drive_op(0, 0, 0, 0, 16'h0, 16'h0);
      @(negedge clk);
      check("R4 accumulate after plain", res_obs, 35'h0_0000_0005);

      // R1: reset in mid-run clears result and operand registers
      drive_op(0, 0, 0, 0, 16'h7, 16'h7);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", res_obs, 35'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 operand registers cleared", res_obs, 35'h0);
      @(negedge clk);
      check("R2 first product after reset", res_obs, 35'h0_0000_0031);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule